// File: doc/BRIEF.md
# Register-Mapped Full-Duplex Serial Port

This block is an asynchronous serial transmitter and receiver. Software drives it over a small byte-wide register bus that has two addresses: a control/status register and a data register. Writing the data address hands a byte to the transmitter and starts a frame on `txd`. Reading the data address returns the most recently received byte from a holding buffer. Because of that buffer, the receive shifter can already be taking in the next frame while software still owns the previous byte.

Each frame is a low start bit, then the data bits least-significant first, then one high stop bit. The line idles high. A mode bit picks 8-bit or 9-bit framing. In 9-bit framing, the extra transmitted bit comes from a control bit, and the extra received bit is stored in another control bit. A single `baud_tick` enable, arriving at 16 times the bit rate from outside the block, paces both directions.

Two sticky flags mark the events, one for transmit done and one for byte received. Hardware only sets them; software clears them. The interrupt output is high while either flag is set and interrupts are enabled.

The transmitter is a state machine with states TX_IDLE, TX_START, TX_DATA and TX_STOP. Its transitions are:
- idle→start on an accepted data write,
- start→data after one bit time,
- data→data per bit,
- data→stop after the last data bit,
- stop→idle after one bit time, with the done flag set at that point.

The receiver is a state machine with states RX_IDLE, RX_START, RX_DATA and RX_STOP. Its transitions are:
- idle→start when the line is sampled low while the receiver is enabled,
- start→idle when the line is high again at mid-bit (a false start),
- start→data when the line is still low at mid-bit,
- data→data per bit,
- data→stop after the last data bit,
- stop→idle at the middle of the stop bit.

Clearing the receive enable forces the receiver to RX_IDLE from any state.

Top module: `uart_sfr`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is high and `irq` is low. Control bit layout: bit0 transmit-done flag, bit1 receive flag, bit2 9-bit mode, bit3 ninth bit to send, bit4 ninth bit received, bit5 receive enable, bit6 interrupt enable, bit7 overrun. `bus_addr` 0 selects control and 1 selects data.
- R2: In 8-bit mode a write to the data address while idle sends the frame start(0), d0..d7, stop(1). Each bit lasts 16 `baud_tick` pulses, and `txd` is high whenever no frame is in progress.
- R3: In 9-bit mode the frame carries a ninth data bit equal to control bit3, placed after d7 and before the stop bit.
- R4: The transmit-done flag is set at the end of the stop bit. It stays set until a control write with bit0 = 0 clears it; a control write with bit0 = 1 leaves it unchanged.
- R5: A data-address write while a frame is being sent is ignored: the frame in progress keeps its data, no second frame follows, and the transmit-done flag is not changed by that write.
- R6: A frame with a high stop bit sets the receive flag, and its byte is then read at the data address. Transmission and reception proceed concurrently without interfering.
- R7: In 9-bit mode the ninth received bit is stored in control bit4.
- R8: Once a byte is in the buffer, the next frame can be received. Reading the data address during that frame returns the earlier byte. If software clears the receive flag before that frame ends, the new byte replaces the earlier one.
- R9: If a frame completes while the receive flag is still set, the byte is discarded, the buffer keeps the earlier byte, and control bit7 (overrun) becomes 1. A control write with bit7 = 0 clears it.
- R10: A frame whose stop bit is sampled low sets no flag and leaves the buffer unchanged.
- R11: A low pulse on `rxd` shorter than half a bit is rejected as a false start, and a valid frame that follows it is received correctly.
- R12: With receive enable (bit5) at 0 the receiver ignores `rxd`: no flag is set and the buffer is unchanged.
- R13: `irq` is high exactly when bit6 is 1 and bit0 or bit1 is 1. Raising `irq` clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
Two receive cases are the hardest to reach from the ports. In the first, a second frame arrives while the first byte is still held. In the second, software clears the flag partway through that second frame. The bench drives two frames back to back on `rxd`. About halfway through the second frame it reads the data address and clears the flag, and it then checks that the second byte replaced the first. For the overrun case it leaves the flag set instead. The transmit and receive paths are also swept over all 256 byte values at the same time, with the transmitted and received bytes differing, so any interaction between the two directions shows up.

// File: rtl/uart_sfr_pkg.sv
package uart_sfr_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    localparam int B_TI   = 0;
    localparam int B_RI   = 1;
    localparam int B_NINE = 2;
    localparam int B_TB9  = 3;
    localparam int B_RB9  = 4;
    localparam int B_REN  = 5;
    localparam int B_IE   = 6;
    localparam int B_OVR  = 7;
endpackage

// File: rtl/uart_sfr_tx.sv
module uart_sfr_tx
    import uart_sfr_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              nine,
    input  logic [DATA_W-1:0] din,
    input  logic              bit9,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 2);

    tx_state_t         state, nxt;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [DATA_W:0]   sh;
    logic              frame_nine;
    logic              bit_end;
    logic              last_bit;

    assign bit_end  = tick && (tcnt == CNT_W'(OVS - 1));
    assign last_bit = frame_nine ? (bcnt == BIT_W'(DATA_W)) : (bcnt == BIT_W'(DATA_W - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (start)    nxt = TX_START;
            TX_START: if (bit_end)  nxt = TX_DATA;
            TX_DATA:  if (bit_end && last_bit) nxt = TX_STOP;
            TX_STOP:  if (bit_end)  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt       <= '0;
            bcnt       <= '0;
            sh         <= '0;
            frame_nine <= 1'b0;
        end else if (state == TX_IDLE) begin
            tcnt <= '0;
            bcnt <= '0;
            if (start) begin
                sh         <= {bit9, din};
                frame_nine <= nine;
            end
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (state == TX_DATA && bit_end) begin
                sh   <= sh >> 1;
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_STOP:  txd = 1'b1;
        endcase
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && bit_end;
    end
endmodule

// File: rtl/uart_sfr_rx.sv
module uart_sfr_rx
    import uart_sfr_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              rxd,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] dout,
    output logic              bit9
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 2);
    localparam int HALF  = OVS / 2;

    rx_state_t         state, nxt;
    logic [1:0]        sync;
    logic              line;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [DATA_W:0]   sh;
    logic              frame_nine;
    logic              mid_start;
    logic              bit_end;
    logic              last_bit;

    assign line      = sync[1];
    assign mid_start = tick && (tcnt == CNT_W'(HALF - 1));
    assign bit_end   = tick && (tcnt == CNT_W'(OVS - 1));
    assign last_bit  = frame_nine ? (bcnt == BIT_W'(DATA_W)) : (bcnt == BIT_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !line) nxt = RX_START;
            RX_START: if (mid_start)     nxt = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && last_bit) nxt = RX_STOP;
            RX_STOP:  if (bit_end)       nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt       <= '0;
            bcnt       <= '0;
            sh         <= '0;
            frame_nine <= 1'b0;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: begin
                    tcnt       <= '0;
                    bcnt       <= '0;
                    frame_nine <= nine;
                end
                RX_START: tcnt <= mid_start ? '0 : tcnt + 1'b1;
                RX_DATA: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        sh   <= {line, sh[DATA_W:1]};
                        bcnt <= bcnt + 1'b1;
                    end
                end
                RX_STOP: tcnt <= bit_end ? '0 : tcnt + 1'b1;
            endcase
        end
    end

    always_comb begin
        active = (state != RX_IDLE);
        done   = (state == RX_STOP) && bit_end && line && en;
        dout   = frame_nine ? sh[DATA_W-1:0] : sh[DATA_W:1];
        bit9   = sh[DATA_W];
    end
endmodule

// File: rtl/uart_sfr.sv
module uart_sfr
    import uart_sfr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int DATA_W = 8;

    logic ti_q, ri_q, ovr_q, nine_q, tb9_q, rb9_q, ren_q, ie_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic tx_start, tx_busy, tx_done;
    logic rx_active, rx_done, rx_bit9;
    logic [DATA_W-1:0] rx_data;
    logic ctrl_wr;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign tx_start = bus_wr && (bus_addr == ADDR_DATA) && !tx_busy;

    uart_sfr_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
        .nine(nine_q), .din(bus_wdata), .bit9(tb9_q),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart_sfr_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ren_q),
        .nine(nine_q), .rxd(rxd), .active(rx_active), .done(rx_done),
        .dout(rx_data), .bit9(rx_bit9)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ti_q <= 1'b0; ri_q <= 1'b0; ovr_q <= 1'b0;
            nine_q <= 1'b0; tb9_q <= 1'b0; rb9_q <= 1'b0;
            ren_q <= 1'b0; ie_q <= 1'b0;
            rx_buf_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ti_q   <= ti_q  & bus_wdata[B_TI];
                ri_q   <= ri_q  & bus_wdata[B_RI];
                ovr_q  <= ovr_q & bus_wdata[B_OVR];
                nine_q <= bus_wdata[B_NINE];
                tb9_q  <= bus_wdata[B_TB9];
                rb9_q  <= bus_wdata[B_RB9];
                ren_q  <= bus_wdata[B_REN];
                ie_q   <= bus_wdata[B_IE];
            end
            if (tx_done) ti_q <= 1'b1;
            if (rx_done) begin
                if (ri_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    ri_q     <= 1'b1;
                    rx_buf_q <= rx_data;
                    if (nine_q) rb9_q <= rx_bit9;
                end
            end
        end
    end

    always_comb begin
        if (bus_addr == ADDR_DATA) bus_rdata = rx_buf_q;
        else bus_rdata = {ovr_q, ie_q, ren_q, rb9_q, tb9_q, nine_q, ri_q, ti_q};
        irq = ie_q && (ti_q || ri_q);
    end
endmodule

// File: rtl/uart_sfr_chk.sv
module uart_sfr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       ti_q,
    input logic       ri_q,
    input logic       ovr_q,
    input logic       ren_q,
    input logic       ie_q,
    input logic       tx_busy,
    input logic       rx_active,
    input logic       rx_done,
    input logic [7:0] rx_buf_q,
    input logic       txd,
    input logic       irq
);
    // R2: line idles high whenever the transmitter is not busy
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R4: transmit flag is cleared only by a control write
    a_r4_ti_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_q && !ctrl_wr) |=> ti_q);

    // R6: receive flag is cleared only by a control write
    a_r6_ri_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_q && !ctrl_wr) |=> ri_q);

    // R9: frame completing with flag still set keeps the buffer and flags overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ri_q) |=> (ovr_q && $stable(rx_buf_q)));

    // R12: receiver held idle when disabled
    a_r12_ren_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_q |=> !rx_active);

    // R13: no interrupt without enable
    a_r13_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq);
endmodule

bind uart_sfr uart_sfr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ti_q(ti_q), .ri_q(ri_q),
    .ovr_q(ovr_q), .ren_q(ren_q), .ie_q(ie_q), .tx_busy(tx_busy),
    .rx_active(rx_active), .rx_done(rx_done), .rx_buf_q(rx_buf_q),
    .txd(txd), .irq(irq)
);

// File: tb/uart_sfr_tb.sv
module uart_sfr_tb;
    localparam int BITCLK = 32;

    logic clk = 0, rst_n = 0, baud_tick = 0;
    logic bus_addr = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic rxd = 1, txd, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [8:0] got;
    logic got_start, got_stop, got_found;
    logic [7:0] rv;

    uart_sfr u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        baud_tick = ~baud_tick;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send_rx(input logic [8:0] v, input int nb, input logic stopv);
        @(negedge clk);
        rxd = 0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = v[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stopv;
        repeat (BITCLK) @(negedge clk);
        rxd = 1;
    endtask

    task automatic recv_tx(input int nb);
        got = '0; got_found = 0; got_start = 1; got_stop = 0;
        for (int w = 0; w < 200 && !got_found; w++) begin
            @(negedge clk);
            if (!txd) got_found = 1;
        end
        repeat (BITCLK / 2) @(negedge clk);
        got_start = txd;
        for (int i = 0; i < nb; i++) begin
            repeat (BITCLK) @(negedge clk);
            got[i] = txd;
        end
        repeat (BITCLK) @(negedge clk);
        got_stop = txd;
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] c, d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        bus_read(0, c);
        chk(c == 8'h00, "R1 ctrl reset", c, 0);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(irq == 1'b0, "R1 irq low", irq, 0);

        // R2 R4 R6 full-duplex sweep, 8-bit mode
        bus_write(0, 8'h60);
        for (int v = 0; v < 256; v++) begin
            bus_write(1, 8'(v));
            fork
                recv_tx(8);
                send_rx(9'(255 - v), 8, 1'b1);
            join
            repeat (8) @(negedge clk);
            chk(got_found && !got_start && got_stop && got[7:0] == 8'(v), "R2 tx frame", int'(got), v);
            bus_read(1, d);
            chk(d == 8'(255 - v), "R6 rx byte", d, 255 - v);
            bus_read(0, c);
            chk(c[1:0] == 2'b11 && irq, "R4 R13 flags set", c, 8'h63);
            bus_write(0, 8'h60);
        end
        bus_read(0, c);
        chk(c[1:0] == 2'b00 && !irq, "R4 flags cleared", c, 8'h60);

        // R3 R7 9-bit mode
        for (int k = 0; k < 8; k++) begin
            logic [7:0] bv;
            logic t9;
            bv = (k[1:0] == 0) ? 8'h00 : (k[1:0] == 1) ? 8'h5A : (k[1:0] == 2) ? 8'hA5 : 8'hFF;
            t9 = k[2];
            bus_write(0, {4'b0110, t9, 3'b100});
            bus_write(1, bv);
            fork
                recv_tx(9);
                send_rx({~t9, ~bv}, 9, 1'b1);
            join
            repeat (8) @(negedge clk);
            chk(got_stop && got == {t9, bv}, "R3 ninth tx bit", int'(got), int'({t9, bv}));
            bus_read(1, d);
            bus_read(0, c);
            chk(d == ~bv && c[4] == ~t9, "R7 ninth rx bit", int'({c[4], d}), int'({~t9, ~bv}));
        end

        // R5 write while busy ignored
        bus_write(0, 8'h60);
        bus_write(1, 8'h3C);
        fork
            recv_tx(8);
            begin
                repeat (100) @(negedge clk);
                bus_write(1, 8'hC3);
                bus_read(0, c);
                chk(c[0] == 1'b0, "R5 ti unchanged by busy write", c[0], 0);
            end
        join
        chk(got[7:0] == 8'h3C, "R5 frame keeps data", got[7:0], 8'h3C);
        begin
            bit quiet = 1;
            repeat (400) begin
                @(negedge clk);
                if (!txd) quiet = 0;
            end
            chk(quiet, "R5 no second frame", quiet, 1);
        end

        // R4 stickiness and R13 gating
        bus_read(0, c);
        chk(c[0] && irq, "R4 ti still set", c, 8'h61);
        bus_write(0, 8'h61);
        bus_read(0, c);
        chk(c[0] == 1'b1, "R4 write of 1 keeps ti", c[0], 1);
        bus_write(0, 8'h21);
        chk(irq == 1'b0, "R13 irq gated by enable", irq, 0);
        bus_write(0, 8'h60);
        bus_read(0, c);
        chk(c[0] == 1'b0 && !irq, "R4 ti cleared", c, 8'h60);

        // R8 buffered reception
        send_rx(9'h11, 8, 1'b1);
        fork
            send_rx(9'h22, 8, 1'b1);
            begin
                repeat (150) @(negedge clk);
                bus_read(1, d);
                chk(d == 8'h11, "R8 old byte held during next frame", d, 8'h11);
                bus_write(0, 8'h60);
            end
        join
        repeat (8) @(negedge clk);
        bus_read(1, d);
        bus_read(0, c);
        chk(d == 8'h22 && c[1] && !c[7], "R8 next byte buffered", int'({c, d}), 16'h6222);

        // R9 overrun
        send_rx(9'h33, 8, 1'b1);
        repeat (8) @(negedge clk);
        bus_read(1, d);
        bus_read(0, c);
        chk(d == 8'h22 && c[7], "R9 overrun keeps byte", int'({c, d}), 16'hE222);
        bus_write(0, 8'h60);
        bus_read(0, c);
        chk(c[7] == 1'b0 && c[1] == 1'b0, "R9 overrun cleared", c, 8'h60);

        // R10 bad stop bit
        send_rx(9'h44, 8, 1'b0);
        repeat (64) @(negedge clk);
        bus_read(1, d);
        bus_read(0, c);
        chk(d == 8'h22 && !c[1], "R10 framing error dropped", int'({c, d}), 16'h6022);

        // R11 false start
        @(negedge clk);
        rxd = 0;
        repeat (6) @(negedge clk);
        rxd = 1;
        repeat (64) @(negedge clk);
        bus_read(0, c);
        chk(!c[1], "R11 glitch ignored", c[1], 0);
        send_rx(9'h55, 8, 1'b1);
        repeat (8) @(negedge clk);
        bus_read(1, d);
        chk(d == 8'h55, "R11 frame after glitch", d, 8'h55);

        // R12 receiver disabled
        bus_write(0, 8'h40);
        send_rx(9'h66, 8, 1'b1);
        repeat (8) @(negedge clk);
        bus_read(1, d);
        bus_read(0, c);
        chk(d == 8'h55 && !c[1] && !irq, "R12 disabled receiver", int'({c, d}), 16'h4055);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule